// File: doc/BRIEF.md
# Turbo Clock Rate Selector

This block derives the CPU's cycle cadence from a single master clock and lets the system run either at the full master rate or at half of it. A debounced push-button pulse flips a one-bit mode register, so each press alternates between the two rates. The register drives a complementary pair of active-low select outputs, exactly one of which is low at any moment.

A supervisory controller can pin the mode with two level-sensitive, active-low force inputs, one for each rate. The system reset acts as a force toward the half rate, so the block always starts in a known mode. While a force is held, the select outputs follow it at once, without waiting for a clock edge, and the register keeps the forced value after the force is released. Asserting both forces at once is an illegal input; the block flags it and resolves it toward the half rate.

There is no gated clock. A toggle register divides the master clock by two, giving a 50:50 half-rate wave, and the block emits a clock-enable pulse `cpuEn` that is high once per CPU cycle. The rate that governs `cpuEn` is taken from the mode register only at the end of a half-rate period. A rate change therefore never produces a shortened CPU cycle.

Top module: `turboClkSel`

## Requirements
- R1: While `rstN` is low, `selHalfN`=0, `selFullN`=1, `halfClk`=0 and `cpuEn`=0, whatever the other inputs are.
- R2: `btnPulse` passes through 2 synchronizer flops. A rise that is sampled at clock edge k changes the mode at edge k+2. A pulse held high for many cycles toggles the mode only once.
- R3: Exactly one of `selHalfN` and `selFullN` is low at all times. `selHalfN`=0 means the half-rate mode and `selFullN`=0 means the full-rate mode.
- R4: While `forceFullN` is low and `forceHalfN` is high, `selFullN` is 0 without waiting for a clock edge, and the button is ignored. After the release the mode stays full-rate.
- R5: While `forceHalfN` is low, or while `rstN` is low, `selHalfN` is 0 without waiting for a clock edge, and the button is ignored. After the release the mode stays half-rate.
- R6: `illegalForce` is 1 exactly when `forceFullN` and `forceHalfN` are both low. In that case the half-rate force wins.
- R7: `halfClk` is 1 in the first cycle after reset and inverts on every master clock edge.
- R8: When the governing rate is full, `cpuEn` is 1 in every cycle. When it is half, `cpuEn` equals `halfClk`.
- R9: The governing rate copies the mode only at edges where `halfClk` was 1. Because of this, `cpuEn` is never high while `halfClk` is low unless it was also high in the cycle before, and a low `cpuEn` lasts at most one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low system reset, forces the half rate |
| btnPulse | input | 1 | Debounced button level, where each rise toggles the mode |
| forceFullN | input | 1 | Active-low level force to the full rate |
| forceHalfN | input | 1 | Active-low level force to the half rate |
| selHalfN | output | 1 | Low when the half-rate mode is selected |
| selFullN | output | 1 | Low when the full-rate mode is selected |
| illegalForce | output | 1 | Both forces asserted together |
| halfClk | output | 1 | Divide-by-2 toggle of the master clock |
| cpuEn | output | 1 | One-cycle enable per CPU cycle |

## Verification
The select outputs respond to the forces in the same cycle. The bench checks them 1 ns after it changes a force, before any clock edge. A button rise changes the selects two edges after it is sampled, and the directed test checks that the selects are still unchanged after the first and second edges and have changed after the third. `halfClk`, `cpuEn` and the governing rate advance one edge at a time. A cycle-level reference in the bench is updated at each rising edge and compared at the following falling edge. Inputs change 1 ns after a falling edge, so each comparison sees the inputs that were present at the edge that produced the state.

// File: rtl/turboClkPkg.sv
package turboClkPkg;
  // Request from mode control to the rate datapath.
  typedef struct packed {
    logic wantFull;   // mode currently selected (forces applied)
  } modeReq_t;
endpackage

// File: rtl/modeCtrl.sv
module modeCtrl
  import turboClkPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     btnPulse,
  input  logic     forceFullN,
  input  logic     forceHalfN,
  output logic     selHalfN,
  output logic     selFullN,
  output logic     illegalForce,
  output modeReq_t req
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          prevQ;
  logic          modeQ;
  logic          btnRise;
  logic          halfAct;
  logic          fullAct;
  logic          modeNow;

  // Button synchronizer chain.
  generate
    if (SYNC_STAGES == 1) begin : gSync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= btnPulse;
      end
    end else begin : gSyncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[LAST-1:0], btnPulse};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[LAST];
  end

  assign btnRise = syncQ[LAST] & ~prevQ;

  // Reset acts like the half-rate force; half-rate force wins on conflict.
  assign halfAct = ~forceHalfN | ~rstN;
  assign fullAct = ~forceFullN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          modeQ <= 1'b0;
    else if (halfAct)   modeQ <= 1'b0;
    else if (fullAct)   modeQ <= 1'b1;
    else if (btnRise)   modeQ <= ~modeQ;
  end

  // Level overrides show through immediately.
  always_comb begin
    if (halfAct)      modeNow = 1'b0;
    else if (fullAct) modeNow = 1'b1;
    else              modeNow = modeQ;
  end

  assign selFullN     = ~modeNow;
  assign selHalfN     = modeNow;
  assign illegalForce = ~forceFullN & ~forceHalfN;
  assign req.wantFull = modeNow;
endmodule

// File: rtl/rateGen.sv
module rateGen
  import turboClkPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  modeReq_t req,
  output logic     halfClk,
  output logic     cpuEn
);
  logic halfQ;
  logic fullApplied;

  // Free-running divide-by-2.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) halfQ <= 1'b0;
    else       halfQ <= ~halfQ;
  end

  // Rate is adopted only at the end of a half-rate period.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      fullApplied <= 1'b0;
    else if (halfQ) fullApplied <= req.wantFull;
  end

  assign halfClk = halfQ;
  assign cpuEn   = fullApplied | halfQ;
endmodule

// File: rtl/turboClkSel.sv
module turboClkSel
  import turboClkPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic btnPulse,
  input  logic forceFullN,
  input  logic forceHalfN,
  output logic selHalfN,
  output logic selFullN,
  output logic illegalForce,
  output logic halfClk,
  output logic cpuEn
);
  modeReq_t req;

  modeCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .btnPulse(btnPulse),
    .forceFullN(forceFullN), .forceHalfN(forceHalfN),
    .selHalfN(selHalfN), .selFullN(selFullN),
    .illegalForce(illegalForce), .req(req)
  );

  rateGen uRate (
    .clk(clk), .rstN(rstN), .req(req),
    .halfClk(halfClk), .cpuEn(cpuEn)
  );
endmodule

// File: rtl/turboClkSelChk.sv
module turboClkSelChk (
  input logic clk,
  input logic rstN,
  input logic forceFullN,
  input logic forceHalfN,
  input logic selHalfN,
  input logic selFullN,
  input logic illegalForce,
  input logic halfClk,
  input logic cpuEn
);
  a_r3_one_select: assert property (@(posedge clk) disable iff (!rstN)
    selHalfN != selFullN);
  a_r4_force_full: assert property (@(posedge clk) disable iff (!rstN)
    (!forceFullN && forceHalfN) |-> !selFullN);
  a_r5_force_half: assert property (@(posedge clk) disable iff (!rstN)
    !forceHalfN |-> !selHalfN);
  a_r6_illegal_flag: assert property (@(posedge clk) disable iff (!rstN)
    illegalForce |-> (!forceFullN && !forceHalfN && !selHalfN));
  a_r7_half_toggles: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (halfClk != $past(halfClk)));
  a_r8_half_enables: assert property (@(posedge clk) disable iff (!rstN)
    halfClk |-> cpuEn);
  a_r9_no_short_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (cpuEn && !halfClk) |-> $past(cpuEn));
  a_r9_gap_max_one: assert property (@(posedge clk) disable iff (!rstN)
    !cpuEn |=> cpuEn);
endmodule

bind turboClkSel turboClkSelChk uChk (
  .clk(clk), .rstN(rstN), .forceFullN(forceFullN), .forceHalfN(forceHalfN),
  .selHalfN(selHalfN), .selFullN(selFullN), .illegalForce(illegalForce),
  .halfClk(halfClk), .cpuEn(cpuEn)
);

// File: tb/tb_turboClkSel.sv
`timescale 1ns/1ps
module tb_turboClkSel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic btnPulse = 1'b0;
  logic forceFullN = 1'b1;
  logic forceHalfN = 1'b1;
  logic selHalfN, selFullN, illegalForce, halfClk, cpuEn;

  int total = 0;
  int bad = 0;
  bit modelOn = 1'b0;
  bit done = 1'b0;

  turboClkSel dut (
    .clk(clk), .rstN(rstN), .btnPulse(btnPulse),
    .forceFullN(forceFullN), .forceHalfN(forceHalfN),
    .selHalfN(selHalfN), .selFullN(selFullN), .illegalForce(illegalForce),
    .halfClk(halfClk), .cpuEn(cpuEn)
  );

  always #4 clk = ~clk;

  // Cycle-level reference built from the requirements.
  logic [1:0] refSync;
  logic refPrev, refMode, refHalf, refApp;

  function automatic logic wantFull(logic m, logic ff, logic fh, logic r);
    if (!fh || !r) return 1'b0;
    if (!ff)       return 1'b1;
    return m;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSync <= 2'b00; refPrev <= 1'b0; refMode <= 1'b0;
      refHalf <= 1'b0;  refApp  <= 1'b0;
    end else begin
      refSync <= {refSync[0], btnPulse};
      refPrev <= refSync[1];
      if (!forceHalfN)                refMode <= 1'b0;
      else if (!forceFullN)           refMode <= 1'b1;
      else if (refSync[1] && !refPrev) refMode <= ~refMode;
      refHalf <= ~refHalf;
      if (refHalf) refApp <= wantFull(refMode, forceFullN, forceHalfN, rstN);
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkModel();
    logic wf;
    wf = wantFull(refMode, forceFullN, forceHalfN, rstN);
    check("R3", "selFullN", selFullN, ~wf);
    check("R3", "selHalfN", selHalfN, wf);
    check("R6", "illegalForce", illegalForce, ~forceFullN & ~forceHalfN);
    check("R7", "halfClk", halfClk, refHalf);
    check("R8", "cpuEn", cpuEn, refApp | refHalf);
  endtask

  always @(negedge clk) if (modelOn) checkModel();

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic m0;
    void'($urandom(32'd4711));
    // R1: reset state, even with the full force and the button active
    forceFullN = 1'b0; btnPulse = 1'b1;
    step(3);
    check("R1", "selHalfN", selHalfN, 1'b0);
    check("R1", "selFullN", selFullN, 1'b1);
    check("R1", "halfClk", halfClk, 1'b0);
    check("R1", "cpuEn", cpuEn, 1'b0);
    forceFullN = 1'b1; btnPulse = 1'b0;
    step(1);
    rstN = 1'b1;
    step(1);
    check("R7", "halfClk first cycle", halfClk, 1'b1);
    check("R8", "cpuEn first cycle", cpuEn, 1'b1);
    modelOn = 1'b1;
    step(4);

    // R2: latency and single toggle on a held pulse
    m0 = selHalfN;
    btnPulse = 1'b1;
    step(1);
    check("R2", "mode after edge k", selHalfN, m0);
    step(1);
    check("R2", "mode after edge k+1", selHalfN, m0);
    step(1);
    check("R2", "mode after edge k+2", selHalfN, ~m0);
    step(10);
    check("R2", "held pulse toggles once", selHalfN, ~m0);
    btnPulse = 1'b0;
    step(4);

    // R4: the full force acts immediately and sticks after release
    forceFullN = 1'b0; #1;
    check("R4", "selFullN immediate", selFullN, 1'b0);
    btnPulse = 1'b1; step(6);
    check("R4", "button ignored", selFullN, 1'b0);
    btnPulse = 1'b0; step(4);
    forceFullN = 1'b1; step(3);
    check("R4", "sticks after release", selFullN, 1'b0);

    // R5: the half force acts immediately and sticks after release
    forceHalfN = 1'b0; #1;
    check("R5", "selHalfN immediate", selHalfN, 1'b0);
    btnPulse = 1'b1; step(6);
    check("R5", "button ignored", selHalfN, 1'b0);
    btnPulse = 1'b0; step(4);
    forceHalfN = 1'b1; step(3);
    check("R5", "sticks after release", selHalfN, 1'b0);

    // R6: both forces low
    forceFullN = 1'b0; forceHalfN = 1'b0; #1;
    check("R6", "illegal flag", illegalForce, 1'b1);
    check("R6", "half wins", selHalfN, 1'b0);
    step(3);
    forceFullN = 1'b1; forceHalfN = 1'b1; #1;
    check("R6", "flag clears", illegalForce, 1'b0);
    step(2);

    // R8, R9: random mix of presses and forces, checked every cycle
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 6)       btnPulse = ~btnPulse;
      else if (r < 8)  forceFullN = ~forceFullN;
      else if (r < 10) forceHalfN = ~forceHalfN;
      else if (r == 10) begin forceFullN = 1'b1; forceHalfN = 1'b1; end
      step(1);
    end
    forceFullN = 1'b1; forceHalfN = 1'b1; btnPulse = 1'b0;
    step(4);

    // R5: reset mid-run returns to half rate
    rstN = 1'b0; #1;
    check("R5", "reset forces half", selHalfN, 1'b0);
    check("R1", "cpuEn in reset", cpuEn, 1'b0);
    step(2);
    rstN = 1'b1;
    step(6);

    modelOn = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule